// File: doc/BRIEF.md
# Shift-and-Add Filter Engine

This block is a microcoded arithmetic engine for multi-rate digital filters, and it has no multiplier. A program memory holds 32-bit microinstructions, and each one executes in a single clock. Every instruction reads two operands from a shared pool: sixteen state registers, four arithmetic registers, eight constants and the live sample input. It scales each operand with an arithmetic right shift and can negate it. The two terms are added and the sum is clamped to the 24-bit range. The result goes to a state register, to an arithmetic register, to the sample output, or to a register and the output together. A filter tap is therefore written as a chain of shifted, signed additions.

The program and the constants are loaded through plain write ports while the engine is idle. A start pulse launches execution at a chosen address, and instructions then run one per cycle at consecutive addresses. A marker bit on an instruction flags the end of a subprogram. Another marker bit stops the run and produces a one-cycle completion pulse. Instructions can depend on a flag that earlier instructions set from the sign of their result.

Top module: `sas_filter_engine`

## Requirements
- R1: After reset, `sample_o` is zero and `busy_o`, `done_o`, `slice_o` and `sample_vld_o` are low. Every state, arithmetic and constant register reads as zero until it is written.
- R2: Operand source codes (5 bits) have these meanings:
  - 0–15 select state register n.
  - 16–19 select arithmetic register n−16.
  - 20 selects `sample_i`, sampled in the cycle the instruction executes.
  - 24–31 select constant n−24.
  - 21–23 read zero.
- R3: A shift code s (0–7) shifts its operand arithmetically right by s bits before the operand is negated.
- R4: A set negate bit replaces the shifted operand by its two's-complement negative. The negation is exact, so negating −2^23 gives +2^23 before saturation.
- R5: The sum of the two terms is clamped to 0x7FFFFF when it exceeds that value and to 0x800000 when it is below −2^23. Otherwise the sum is passed through unchanged.
- R6: Destination codes (5 bits) have these meanings:
  - 0–15 write state register n.
  - 16–19 write arithmetic register n−16.
  - Any other code writes no register.
  - When the output bit is set, `sample_o` takes the result and `sample_vld_o` is high for exactly one cycle.
  - Both take effect on the clock edge that ends the instruction.
  - While the engine is idle, `sample_o` holds its value.
- R7: The 2-bit condition field selects when an instruction writes:
  - 0 means always.
  - 1 means only when the flag is set.
  - 2 means only when the flag is clear.
  - 3 means never.

  An instruction whose condition fails writes no register, no output and no flag. When the set-flag bit is set and the instruction executes, the flag takes the sign bit of the saturated result. The flag is zero after reset.
- R8: The edge that samples `start_i` high raises `busy_o` and loads `start_addr_i` as the address of the first instruction. Instructions then execute one per cycle at incrementing addresses, wrapping at the end of memory.
- R9: An instruction with the end bit retires even if its condition fails. On the edge that ends it, `busy_o` falls and `done_o` is high for exactly one cycle.
- R10: When an instruction with the slice bit retires, `slice_o` is high for one cycle.
- R11: `prog_we_i` writes `prog_data_i` at `prog_addr_i`, and `cst_we_i` writes `cst_data_i` into constant `cst_addr_i`. Instruction bit fields, from the LSB upward:
  - source A: bits [4:0]
  - shift A: bits [7:5]
  - negate A: bit [8]
  - source B: bits [13:9]
  - shift B: bits [16:14]
  - negate B: bit [17]
  - destination: bits [22:18]
  - output: bit [23]
  - condition: bits [25:24]
  - set flag: bit [26]
  - slice: bit [27]
  - end: bit [28]

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | 5 | Program memory write address |
| prog_data_i | input | 32 | Instruction word to write |
| cst_we_i | input | 1 | Constant write enable |
| cst_addr_i | input | 3 | Constant index |
| cst_data_i | input | 24 | Constant value |
| start_i | input | 1 | Launch pulse |
| start_addr_i | input | 5 | First instruction address |
| sample_i | input | 24 | Sample input operand |
| sample_o | output | 24 | Last output result |
| sample_vld_o | output | 1 | One-cycle strobe on an output write |
| slice_o | output | 1 | Subprogram end strobe |
| done_o | output | 1 | Program completion strobe |
| busy_o | output | 1 | Engine is executing |

## Verification
Program termination and write suppression can land on the same instruction. An end-flagged instruction whose condition fails must still stop the engine and pulse `done_o`, while it writes no register and leaves `sample_o` untouched. A directed program ends on a never-condition instruction that names the output and a state register. A later run then reads that register back through the output. Random programs also draw a random condition and random slice and output bits for the closing instruction. For every cycle the bench compares the valid strobe, the held output, `done_o` and `busy_o` against its own instruction-level model.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam int SRC_W  = 5;
  localparam int SH_W   = 3;
  localparam int IW     = 32;
  localparam int N_STATE = 16;
  localparam int N_ARITH = 4;
  localparam int N_CONST = 8;
  localparam int ST_AW  = $clog2(N_STATE);
  localparam int AR_AW  = $clog2(N_ARITH);
  localparam int CS_AW  = $clog2(N_CONST);

  localparam logic [SRC_W-1:0] SRC_AR_BASE  = SRC_W'(N_STATE);
  localparam logic [SRC_W-1:0] SRC_AR_END   = SRC_W'(N_STATE + N_ARITH);
  localparam logic [SRC_W-1:0] SRC_INPUT    = SRC_W'(N_STATE + N_ARITH);
  localparam logic [SRC_W-1:0] SRC_CST_BASE = SRC_W'(24);

  typedef enum logic [1:0] {
    COND_ALWAYS   = 2'd0,
    COND_FLAG_SET = 2'd1,
    COND_FLAG_CLR = 2'd2,
    COND_NEVER    = 2'd3
  } cond_e;

  typedef struct packed {
    logic [2:0]       rsvd;
    logic             end_f;
    logic             slice_f;
    logic             set_flag;
    cond_e            cond;
    logic             out_en;
    logic [SRC_W-1:0] dst;
    logic             neg_b;
    logic [SH_W-1:0]  sh_b;
    logic [SRC_W-1:0] src_b;
    logic             neg_a;
    logic [SH_W-1:0]  sh_a;
    logic [SRC_W-1:0] src_a;
  } instr_t;
endpackage

// File: rtl/sas_regfile.sv
module sas_regfile
  import sas_pkg::*;
#(
  parameter int DW  = 24,
  parameter int NRD = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SRC_W-1:0]          wr_dst_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      cst_we_i,
  input  logic [CS_AW-1:0]          cst_addr_i,
  input  logic [DW-1:0]             cst_data_i,
  input  logic [DW-1:0]             sample_i,
  input  logic [NRD-1:0][SRC_W-1:0] rd_src_i,
  output logic [NRD-1:0][DW-1:0]    rd_data_o
);
  logic [DW-1:0] st_q [N_STATE];
  logic [DW-1:0] ar_q [N_ARITH];
  logic [DW-1:0] cs_q [N_CONST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_STATE; i++) st_q[i] <= '0;
      for (int i = 0; i < N_ARITH; i++) ar_q[i] <= '0;
    end else if (wr_en_i) begin
      if (wr_dst_i < SRC_AR_BASE)
        st_q[wr_dst_i[ST_AW-1:0]] <= wr_data_i;
      else if (wr_dst_i < SRC_AR_END)
        ar_q[wr_dst_i[AR_AW-1:0]] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CONST; i++) cs_q[i] <= '0;
    end else if (cst_we_i) begin
      cs_q[cst_addr_i] <= cst_data_i;
    end
  end

  function automatic logic [DW-1:0] read_src(input logic [SRC_W-1:0] src);
    logic [DW-1:0] v;
    v = '0;
    if (src < SRC_AR_BASE)       v = st_q[src[ST_AW-1:0]];
    else if (src < SRC_AR_END)   v = ar_q[src[AR_AW-1:0]];
    else if (src == SRC_INPUT)   v = sample_i;
    else if (src >= SRC_CST_BASE) v = cs_q[src[CS_AW-1:0]];
    return v;
  endfunction

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = read_src(rd_src_i[p]);
  end
endmodule

// File: rtl/sas_scale.sv
module sas_scale
  import sas_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic [DW-1:0]        op_i,
  input  logic [SH_W-1:0]      sh_i,
  input  logic                 neg_i,
  output logic signed [DW:0]   term_o
);
  logic signed [DW-1:0] shd;
  logic signed [DW:0]   ext;

  always_comb begin
    shd    = $signed(op_i) >>> sh_i;
    ext    = {shd[DW-1], shd};
    // one extra bit keeps -(-2^(DW-1)) exact
    term_o = neg_i ? -ext : ext;
  end
endmodule

// File: rtl/sas_sat_add.sv
module sas_sat_add #(
  parameter int DW = 24
) (
  input  logic signed [DW:0]   a_i,
  input  logic signed [DW:0]   b_i,
  output logic [DW-1:0]        res_o
);
  localparam logic signed [DW+1:0] MAXV = {3'b000, {(DW-1){1'b1}}};
  localparam logic signed [DW+1:0] MINV = {3'b111, {(DW-1){1'b0}}};

  logic signed [DW+1:0] sum;

  always_comb begin
    sum = $signed({a_i[DW], a_i}) + $signed({b_i[DW], b_i});
    if (sum > MAXV)      res_o = MAXV[DW-1:0];
    else if (sum < MINV) res_o = MINV[DW-1:0];
    else                 res_o = sum[DW-1:0];
  end
endmodule

// File: rtl/sas_sequencer.sv
module sas_sequencer #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          end_i,
  input  logic          slice_i,
  output logic [AW-1:0] pc_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          slice_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o    <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      slice_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      slice_o <= 1'b0;
      if (busy_o) begin
        pc_o    <= pc_o + 1'b1;
        slice_o <= slice_i;
        if (end_i) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
      // a launch overrides the running sequence
      if (start_i) begin
        pc_o   <= start_addr_i;
        busy_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sas_filter_engine.sv
module sas_filter_engine
  import sas_pkg::*;
#(
  parameter int DW         = 24,
  parameter int PROG_DEPTH = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          prog_we_i,
  input  logic [$clog2(PROG_DEPTH)-1:0] prog_addr_i,
  input  logic [IW-1:0]                 prog_data_i,
  input  logic                          cst_we_i,
  input  logic [CS_AW-1:0]              cst_addr_i,
  input  logic [DW-1:0]                 cst_data_i,
  input  logic                          start_i,
  input  logic [$clog2(PROG_DEPTH)-1:0] start_addr_i,
  input  logic [DW-1:0]                 sample_i,
  output logic [DW-1:0]                 sample_o,
  output logic                          sample_vld_o,
  output logic                          slice_o,
  output logic                          done_o,
  output logic                          busy_o
);
  localparam int AW = $clog2(PROG_DEPTH);
  localparam int NOP = 2;

  logic [IW-1:0] prog_q [PROG_DEPTH];
  logic [AW-1:0] pc;
  instr_t        ins;
  logic          flag_q;
  logic          cond_ok;
  logic          exec;
  logic [DW-1:0] result;

  logic [NOP-1:0][SRC_W-1:0] op_src;
  logic [NOP-1:0][SH_W-1:0]  op_sh;
  logic [NOP-1:0]            op_neg;
  logic [NOP-1:0][DW-1:0]    op_raw;
  logic signed [DW:0]        op_term [NOP];

  always_ff @(posedge clk_i) begin
    if (prog_we_i) prog_q[prog_addr_i] <= prog_data_i;
  end

  assign ins = instr_t'(prog_q[pc]);

  always_comb begin
    unique case (ins.cond)
      COND_ALWAYS:   cond_ok = 1'b1;
      COND_FLAG_SET: cond_ok = flag_q;
      COND_FLAG_CLR: cond_ok = !flag_q;
      default:       cond_ok = 1'b0;
    endcase
  end

  assign exec = busy_o && cond_ok;

  assign op_src = {ins.src_b, ins.src_a};
  assign op_sh  = {ins.sh_b,  ins.sh_a};
  assign op_neg = {ins.neg_b, ins.neg_a};

  sas_sequencer #(.AW(AW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .end_i       (ins.end_f),
    .slice_i     (ins.slice_f),
    .pc_o        (pc),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .slice_o     (slice_o)
  );

  sas_regfile #(.DW(DW), .NRD(NOP)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (exec),
    .wr_dst_i  (ins.dst),
    .wr_data_i (result),
    .cst_we_i  (cst_we_i),
    .cst_addr_i(cst_addr_i),
    .cst_data_i(cst_data_i),
    .sample_i  (sample_i),
    .rd_src_i  (op_src),
    .rd_data_o (op_raw)
  );

  for (genvar k = 0; k < NOP; k++) begin : g_op
    sas_scale #(.DW(DW)) i_scale (
      .op_i  (op_raw[k]),
      .sh_i  (op_sh[k]),
      .neg_i (op_neg[k]),
      .term_o(op_term[k])
    );
  end

  sas_sat_add #(.DW(DW)) i_add (
    .a_i  (op_term[0]),
    .b_i  (op_term[1]),
    .res_o(result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q       <= 1'b0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= exec && ins.out_en;
      if (exec && ins.out_en) sample_o <= result;
      if (exec && ins.set_flag) flag_q <= result[DW-1];
    end
  end
endmodule

// File: rtl/sas_filter_engine_chk.sv
module sas_filter_engine_chk #(
  parameter int DW         = 24,
  parameter int PROG_DEPTH = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic [$clog2(PROG_DEPTH)-1:0] start_addr_i,
  input logic [DW-1:0]                 sample_o,
  input logic                          sample_vld_o,
  input logic                          slice_o,
  input logic                          done_o,
  input logic                          busy_o
);
  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  assert_done_retire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  assert_vld_from_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> $past(busy_o));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(sample_o) && !sample_vld_o));

  assert_slice_from_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slice_o |-> $past(busy_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> (!done_o && !slice_o));
endmodule

bind sas_filter_engine sas_filter_engine_chk #(.DW(DW), .PROG_DEPTH(PROG_DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_addr_i(start_addr_i),
  .sample_o    (sample_o),
  .sample_vld_o(sample_vld_o),
  .slice_o     (slice_o),
  .done_o      (done_o),
  .busy_o      (busy_o)
);

// File: tb/test_sas_filter_engine.sv
`timescale 1ns/1ps
module test_sas_filter_engine;
  localparam int DW = 24;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          prog_we_i = 1'b0;
  logic [AW-1:0] prog_addr_i = '0;
  logic [31:0]   prog_data_i = '0;
  logic          cst_we_i = 1'b0;
  logic [2:0]    cst_addr_i = '0;
  logic [DW-1:0] cst_data_i = '0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [DW-1:0] sample_i = '0;
  logic [DW-1:0] sample_o;
  logic          sample_vld_o, slice_o, done_o, busy_o;

  always #4 clk_i = ~clk_i;

  sas_filter_engine i_sas_filter_engine (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0]   m_prog [DEPTH];
  logic [DW-1:0] m_st [16];
  logic [DW-1:0] m_ar [4];
  logic [DW-1:0] m_cs [8];
  logic          m_flag = 1'b0;
  logic [DW-1:0] m_out = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int sa, int sha, bit na, int sb, int shb, bit nb,
                                     int dst, bit oe, int cnd, bit sf, bit sl, bit en);
    logic [31:0] w;
    w = '0;
    w[4:0] = sa[4:0];  w[7:5] = sha[2:0];  w[8] = na;
    w[13:9] = sb[4:0]; w[16:14] = shb[2:0]; w[17] = nb;
    w[22:18] = dst[4:0]; w[23] = oe; w[25:24] = cnd[1:0];
    w[26] = sf; w[27] = sl; w[28] = en;
    return w;
  endfunction

  function automatic logic [DW-1:0] m_read(logic [4:0] s, logic [DW-1:0] smp);
    if (s < 16) return m_st[s[3:0]];
    if (s < 20) return m_ar[s[1:0]];
    if (s == 20) return smp;
    if (s >= 24) return m_cs[s[2:0]];
    return '0;
  endfunction

  function automatic logic signed [DW:0] f_scale(logic [DW-1:0] v, logic [2:0] sh, logic ng);
    logic signed [DW-1:0] s;
    logic signed [DW:0] e;
    s = $signed(v) >>> sh;
    e = {s[DW-1], s};
    return ng ? -e : e;
  endfunction

  function automatic logic [DW-1:0] f_sat(logic signed [DW:0] a, logic signed [DW:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 8388607) return 24'h7FFFFF;
    if (s < -8388608) return 24'h800000;
    return s[DW-1:0];
  endfunction

  task automatic load_prog(input int addr, input logic [31:0] w);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = addr[AW-1:0]; prog_data_i = w;
    @(negedge clk_i);
    prog_we_i = 1'b0;
    m_prog[addr] = w;
  endtask

  task automatic load_cst(input int idx, input logic [DW-1:0] v);
    @(negedge clk_i);
    cst_we_i = 1'b1; cst_addr_i = idx[2:0]; cst_data_i = v;
    @(negedge clk_i);
    cst_we_i = 1'b0;
    m_cs[idx] = v;
  endtask

  // per-cycle comparison against the instruction-level model
  task automatic run_prog(input int sa, input string req);
    int pc;
    bit fin;
    int guard;
    logic [31:0] w;
    logic [DW-1:0] smp, res;
    logic ok, vexp;
    pc = sa; fin = 1'b0; guard = 0;
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = sa[AW-1:0];
    @(negedge clk_i);
    start_i = 1'b0;
    while (!fin && guard < 64) begin
      guard++;
      smp = DW'($urandom);
      sample_i = smp;
      w = m_prog[pc];
      case (w[25:24])
        2'd0: ok = 1'b1;
        2'd1: ok = m_flag;
        2'd2: ok = !m_flag;
        default: ok = 1'b0;
      endcase
      res = f_sat(f_scale(m_read(w[4:0], smp), w[7:5], w[8]),
                  f_scale(m_read(w[13:9], smp), w[16:14], w[17]));
      if (ok) begin
        if (w[22:18] < 16) m_st[w[21:18]] = res;
        else if (w[22:18] < 20) m_ar[w[19:18]] = res;
        if (w[26]) m_flag = res[DW-1];
        if (w[23]) m_out = res;
      end
      vexp = ok && w[23];
      fin = w[28];
      pc = (pc + 1) % DEPTH;
      @(negedge clk_i);
      chk(sample_vld_o == vexp, req, "R6 out valid", sample_vld_o, vexp);
      chk(sample_o == m_out, req, "out data", sample_o, m_out);
      chk(slice_o == w[27], "R10", "slice", slice_o, w[27]);
      chk(done_o == fin, "R9", "done", done_o, fin);
      chk(busy_o == !fin, "R8", "busy", busy_o, !fin);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9", "done width", done_o, 0);
    chk(sample_vld_o == 1'b0 && sample_o == m_out, "R6", "idle hold", sample_o, m_out);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int len, sa;
    logic [31:0] w;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) m_st[i] = '0;
    for (int i = 0; i < 4; i++) m_ar[i] = '0;
    for (int i = 0; i < 8; i++) m_cs[i] = '0;
    for (int i = 0; i < DEPTH; i++) m_prog[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(sample_o == 0, "R1", "sample_o", sample_o, 0);
    chk(!busy_o && !done_o && !slice_o && !sample_vld_o, "R1", "strobes",
        {busy_o, done_o, slice_o, sample_vld_o}, 0);
    // R1/R11: cleared registers and constant read through the output
    load_prog(0, mk(5, 0, 0, 17, 0, 0, 31, 1, 0, 0, 0, 0));
    load_prog(1, mk(26, 0, 0, 13, 0, 0, 31, 1, 0, 0, 0, 1));
    run_prog(0, "R1/R11");
    chk(sample_o == 0, "R1", "cleared regs", sample_o, 0);

    // R4/R5 saturation and exact negation
    load_cst(0, 24'h7FFFFF);
    load_cst(1, 24'h800000);
    load_cst(2, 24'h000001);
    load_cst(3, 24'h400000);
    load_prog(2, mk(24, 0, 0, 24, 0, 0, 0, 1, 0, 0, 0, 0));
    load_prog(3, mk(25, 0, 0, 25, 0, 0, 31, 1, 0, 0, 0, 0));
    load_prog(4, mk(25, 0, 1, 23, 0, 0, 31, 1, 0, 0, 0, 0));
    load_prog(5, mk(24, 0, 0, 26, 0, 1, 31, 1, 0, 0, 0, 0));
    load_prog(6, mk(25, 0, 0, 26, 0, 1, 31, 1, 0, 0, 0, 1));
    run_prog(2, "R4/R5");
    chk(sample_o == 24'h800000, "R5", "negative clamp", sample_o, 24'h800000);

    // R3 shifts
    load_prog(8, mk(25, 7, 0, 21, 0, 0, 31, 1, 0, 0, 0, 0));
    load_prog(9, mk(27, 3, 0, 27, 1, 1, 17, 1, 0, 0, 0, 0));
    load_prog(10, mk(24, 7, 0, 17, 2, 0, 31, 1, 0, 0, 0, 1));
    run_prog(8, "R3");
    chk(m_ar[1] == 24'hE80000, "R3", "model shift", m_ar[1], 24'hE80000);

    // R2/R6 sources, destinations, output-only code
    load_prog(12, mk(20, 0, 0, 21, 0, 0, 3, 0, 0, 0, 0, 0));
    load_prog(13, mk(20, 1, 0, 22, 0, 0, 18, 0, 0, 0, 1, 0));
    load_prog(14, mk(3, 0, 0, 18, 0, 0, 31, 1, 0, 0, 0, 0));
    load_prog(15, mk(21, 0, 0, 22, 0, 0, 30, 1, 0, 0, 1, 1));
    run_prog(12, "R2/R6");

    // R7 conditions; final instruction ends with a false condition
    load_prog(20, mk(25, 0, 0, 21, 0, 0, 31, 0, 0, 1, 0, 0));
    load_prog(21, mk(24, 0, 0, 21, 0, 0, 7, 1, 2, 0, 0, 0));
    load_prog(22, mk(26, 0, 0, 21, 0, 0, 8, 0, 1, 0, 0, 0));
    load_prog(23, mk(7, 0, 0, 8, 0, 0, 31, 1, 0, 1, 0, 0));
    load_prog(24, mk(24, 0, 0, 21, 0, 0, 8, 1, 3, 0, 1, 1));
    run_prog(20, "R7");
    load_prog(26, mk(7, 0, 0, 8, 0, 0, 31, 1, 0, 0, 0, 1));
    run_prog(26, "R7");
    chk(sample_o == 24'h000001, "R7", "suppressed writes", sample_o, 1);

    // R8 wrap: program straddling the top address
    load_prog(31, mk(26, 0, 0, 26, 0, 0, 31, 1, 0, 0, 0, 0));
    load_prog(0, mk(24, 1, 0, 20, 4, 1, 31, 1, 0, 0, 1, 1));
    run_prog(31, "R8");

    // random programs, R2 R3 R4 R5 R6 R7 R10
    for (int it = 0; it < 40; it++) begin
      if (it % 5 == 0) begin
        for (int c = 0; c < 8; c++) load_cst(c, DW'($urandom));
      end
      len = 3 + ($urandom % 8);
      sa = $urandom % DEPTH;
      for (int k = 0; k < len; k++) begin
        w = mk($urandom % 32, $urandom % 8, 1'($urandom), $urandom % 32, $urandom % 8,
               1'($urandom), $urandom % 32, ($urandom % 4) != 0, $urandom % 4,
               1'($urandom), ($urandom % 6) == 0, k == len - 1);
        load_prog((sa + k) % DEPTH, w);
      end
      run_prog(sa, "R2/R3/R4/R5/R7");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule